// File: doc/BRIEF.md
# Frame Shift and Shutter Sequencer

This block runs the frame-level timing of a frame-transfer image sensor camera. A frame starts with an optional shutter pulse that empties the image area. An integration interval follows, counted in line periods. Then comes a fixed-length burst in which the image-area and storage-area vertical clocks move together. The burst carries all integrated charge into the shielded storage area. While the burst runs, the block raises a request for the higher transport voltage and emits a frame pulse. After the burst it hands each storage line to a separate line sequencer through a request/done handshake. During the black reference lines at both ends of the frame it drives a clamp window.

Integration length and the vertical clock divider are set through configuration inputs. Both are captured at the moment a frame begins. An integration length of zero drops the shutter pulse, so exposure spans the whole preceding readout. While `run` stays high, frames follow one after another. When `run` is low at the end of a readout, the block returns to rest.

Top module: `fts_frame_seq`

## Requirements
- R1: After reset `cr_pulse`, `vd`, `high_req`, `blc` and `line_req` are low, and `a_clk` and `b_clk` both hold 4'b1101.
- R2: When a frame starts with a nonzero integration value I, `cr_pulse` is high for exactly CR_CLKS cycles. It is followed by exactly I*LINE_CLKS cycles with `cr_pulse` and `high_req` low, and then the frame shift begins.
- R3: With integration value 0, no `cr_pulse` occurs. The frame shift starts directly from rest, or directly after the previous readout when `run` is held high.
- R4: The frame shift keeps `high_req` high for exactly SHIFT_LINES*8*N cycles, where N is the divider value and a divider of 0 acts as 1.
- R5: During the shift, clock phase k (bit k of `a_clk`) is high in steps 2k to 2k+4 modulo 8. The step is floor(t/N) mod 8 at shift cycle t, and `b_clk` equals `a_clk`. Outside the shift both buses hold 4'b1101, the step-0 pattern.
- R6: `vd` is high for the first LINE_CLKS cycles of the shift, or for the whole shift if the shift is shorter, and low at all other times.
- R7: After the shift the block issues TOTAL_LINES one-cycle `line_req` pulses with `line_num` counting 0 upward. Each later request comes exactly one cycle after the `line_done` that answers the previous one.
- R8: `blc` is high throughout the readout of lines below BLACK_LINES and lines at or above TOTAL_LINES-BLACK_LINES, and low on the other lines.
- R9: Configuration is captured when a frame begins, so changing it afterwards leaves that frame unchanged. With `run` low at the end of a readout, the block rests with all strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Keep sequencing frames while high |
| cfg_int_lines | input | IW | Integration time in line periods, 0 = no shutter |
| cfg_div_n | input | NW | Pixel clocks per vertical phase step |
| line_done | input | 1 | Line sequencer finished the requested line |
| a_clk | output | 4 | Image-area vertical clock phases |
| b_clk | output | 4 | Storage-area vertical clock phases (during shift) |
| high_req | output | 1 | Request for raised transport level |
| vd | output | 1 | Frame pulse |
| cr_pulse | output | 1 | Charge reset (shutter) pulse |
| blc | output | 1 | Black level clamp window |
| line_req | output | 1 | One-cycle request for the next line readout |
| line_num | output | LW | Index of the requested line |

## Verification
All outputs are decoded from registered state without further flops. A result is due in the cycle after the clock edge that moves the state, and the bench reads the outputs on the falling edge. Shutter length, integration gap and shift length are measured in those falling-edge samples, from the rise to the fall of each strobe. The phase pattern is predicted for every shift cycle from the cycle count since `high_req` rose, divided by N. A new line request is expected exactly one sample after the bench drives `line_done`, and the clamp state is compared both when each request appears and when its done is returned.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CRST  = 3'd1,
    ST_INTEG = 3'd2,
    ST_SHIFT = 3'd3,
    ST_READ  = 3'd4
  } fts_state_e;

  localparam int unsigned PHASE_STEPS = 8;
endpackage

// File: rtl/fts_timer.sv
module fts_timer #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  output logic [TW-1:0] cnt
);
  logic [TW-1:0] cnt_d;

  always_comb begin
    cnt_d = clr ? '0 : cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_d;
  end

  // R4: the interval count advances by one every cycle a state is held
  p_tmr_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt == $past(cnt) + 1'b1);
endmodule

// File: rtl/fts_phase_gen.sv
module fts_phase_gen #(
  parameter int NW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [NW-1:0] n_div,
  output logic [3:0]    a_clk,
  output logic [3:0]    b_clk
);
  logic [NW-1:0] div_q, div_d;
  logic [2:0]    step_q, step_d;
  logic          step_wrap;

  always_comb begin
    step_wrap = (div_q == n_div - 1'b1);
    if (!en) begin
      div_d  = '0;
      step_d = '0;
    end else if (step_wrap) begin
      div_d  = '0;
      step_d = step_q + 3'd1;
    end else begin
      div_d  = div_q + 1'b1;
      step_d = step_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      step_q <= '0;
    end else begin
      div_q  <= div_d;
      step_q <= step_d;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_ph
    logic [2:0] rel;
    assign rel      = step_q - 3'(2 * k);
    assign a_clk[k] = (rel < 3'd5);
    assign b_clk[k] = (rel < 3'd5);
  end

  // R5: the step moves forward by one once N pixel clocks have elapsed
  p_step_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && step_wrap) |=> (!en || step_q == $past(step_q) + 3'd1));
endmodule

// File: rtl/fts_frame_seq.sv
module fts_frame_seq #(
  parameter int LINE_CLKS   = 1184,
  parameter int CR_CLKS     = 90,
  parameter int SHIFT_LINES = 1027,
  parameter int TOTAL_LINES = 1030,
  parameter int BLACK_LINES = 6,
  parameter int IW          = 12,
  parameter int NW          = 4,
  parameter int TW          = 32,
  localparam int LW         = $clog2(TOTAL_LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [IW-1:0] cfg_int_lines,
  input  logic [NW-1:0] cfg_div_n,
  input  logic          line_done,
  output logic [3:0]    a_clk,
  output logic [3:0]    b_clk,
  output logic          high_req,
  output logic          vd,
  output logic          cr_pulse,
  output logic          blc,
  output logic          line_req,
  output logic [LW-1:0] line_num
);
  import fts_pkg::*;

  localparam logic [LW-1:0] LAST_LINE = LW'(TOTAL_LINES - 1);
  localparam logic [LW-1:0] BLK_LO    = LW'(BLACK_LINES);
  localparam logic [LW-1:0] BLK_HI    = LW'(TOTAL_LINES - BLACK_LINES);
  localparam logic [TW-1:0] SHIFT_UNITS = TW'(SHIFT_LINES * PHASE_STEPS);

  fts_state_e    st_q, st_d;
  logic [IW-1:0] int_q, int_d;
  logic [NW-1:0] n_q, n_d, n_eff;
  logic [LW-1:0] line_q, line_d;
  logic          wait_q, wait_d;
  logic [TW-1:0] tmr;
  logic [TW-1:0] integ_end, shift_end;
  logic          frame_go;

  assign n_eff     = (n_q == '0) ? NW'(1) : n_q;
  assign integ_end = TW'(int_q) * TW'(LINE_CLKS) - 1'b1;
  assign shift_end = SHIFT_UNITS * TW'(n_eff) - 1'b1;

  always_comb begin
    st_d     = st_q;
    frame_go = 1'b0;
    line_d   = line_q;
    wait_d   = wait_q;
    case (st_q)
      ST_IDLE: begin
        if (run) begin
          frame_go = 1'b1;
          st_d     = (cfg_int_lines == '0) ? ST_SHIFT : ST_CRST;
        end
      end
      ST_CRST:  if (tmr == TW'(CR_CLKS - 1)) st_d = ST_INTEG;
      ST_INTEG: if (tmr == integ_end)        st_d = ST_SHIFT;
      ST_SHIFT: if (tmr == shift_end)        st_d = ST_READ;
      ST_READ: begin
        if (!wait_q) begin
          wait_d = 1'b1;
        end else if (line_done) begin
          wait_d = 1'b0;
          if (line_q == LAST_LINE) begin
            if (run) begin
              frame_go = 1'b1;
              st_d     = (cfg_int_lines == '0) ? ST_SHIFT : ST_CRST;
            end else begin
              st_d = ST_IDLE;
            end
          end else begin
            line_d = line_q + 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (st_d != ST_READ) begin
      line_d = '0;
      wait_d = 1'b0;
    end
    int_d = frame_go ? cfg_int_lines : int_q;
    n_d   = frame_go ? cfg_div_n     : n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      int_q  <= '0;
      n_q    <= '0;
      line_q <= '0;
      wait_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      int_q  <= int_d;
      n_q    <= n_d;
      line_q <= line_d;
      wait_q <= wait_d;
    end
  end

  fts_timer #(.TW(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (st_d != st_q),
    .cnt   (tmr)
  );

  fts_phase_gen #(.NW(NW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (st_q == ST_SHIFT),
    .n_div (n_eff),
    .a_clk (a_clk),
    .b_clk (b_clk)
  );

  assign high_req = (st_q == ST_SHIFT);
  assign vd       = (st_q == ST_SHIFT) && (tmr < TW'(LINE_CLKS));
  assign cr_pulse = (st_q == ST_CRST);
  assign line_req = (st_q == ST_READ) && !wait_q;
  assign line_num = line_q;
  assign blc      = (st_q == ST_READ) && ((line_q < BLK_LO) || (line_q >= BLK_HI));

  // R2: the shutter never overlaps transport or readout activity
  p_cr_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cr_pulse |-> (!high_req && !line_req && !blc));
  // R6: the frame pulse only appears inside the shift burst
  p_vd_in_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    vd |-> high_req);
  // R5: outside the burst the phase generator rests on the hold pattern
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !high_req |-> (a_clk == 4'b1101 && b_clk == 4'b1101));
  // R7: a line request lasts one cycle
  p_req_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_req |=> !line_req);
  // R7: the line index moves only on a done
  p_line_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_done |=> $stable(line_num));
  // R8: the clamp window stays out of the transport burst
  p_blc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blc |-> !high_req);
endmodule

// File: tb/tb_fts_frame_seq.sv
module tb_fts_frame_seq;
  localparam int LC = 16, CRC = 6, SL = 5, TL = 12, BL = 2, IW = 12, NW = 4;
  localparam int LW = $clog2(TL);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [IW-1:0] cfg_int = '0;
  logic [NW-1:0] cfg_n = NW'(1);
  logic line_done = 1'b0;
  logic [3:0] a_clk, b_clk;
  logic high_req, vd, cr_pulse, blc, line_req;
  logic [LW-1:0] line_num;

  fts_frame_seq #(.LINE_CLKS(LC), .CR_CLKS(CRC), .SHIFT_LINES(SL),
    .TOTAL_LINES(TL), .BLACK_LINES(BL), .IW(IW), .NW(NW), .TW(32)) dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_int_lines(cfg_int),
    .cfg_div_n(cfg_n), .line_done(line_done), .a_clk(a_clk), .b_clk(b_clk),
    .high_req(high_req), .vd(vd), .cr_pulse(cr_pulse), .blc(blc),
    .line_req(line_req), .line_num(line_num));

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int exp_int = 0, exp_n = 1;
  int fs_t = 0, fs_bad = 0, vd_bad = 0, hold_bad = 0;
  int cr_len = 0, gap = 0, exp_line = 0, lines_seen = 0, dly = 0;
  int since_done = -1, frames = 0;
  bit gap_on = 0, cr_seen = 0, hr_q = 0, cr_q = 0, mon_on = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pat(input int s);
    logic [3:0] p;
    for (int k = 0; k < 4; k++) p[k] = (((s - 2 * k + 8) % 8) < 5);
    return p;
  endfunction

  function automatic bit isblk(input int l);
    return (l < BL) || (l >= TL - BL);
  endfunction

  always @(negedge clk) begin
    if (mon_on) begin
      line_done = 1'b0;
      if (cr_pulse) begin cr_len++; cr_seen = 1; end
      if (cr_q && !cr_pulse) begin
        chk(cr_len == CRC, "R2", "shutter length", cr_len, CRC);
        cr_len = 0; gap_on = 1; gap = 0;
      end
      if (gap_on && !cr_pulse && !high_req) gap++;
      if (high_req) begin
        if (!hr_q) begin
          if (cr_seen) chk(gap == exp_int * LC, "R2", "integration cycles", gap, exp_int * LC);
          else chk(exp_int == 0, "R3", "shutter skipped only at zero", exp_int, 0);
          if (frames > 0) chk(lines_seen == TL, "R7", "lines per frame", lines_seen, TL);
          frames++; lines_seen = 0;
          gap_on = 0; cr_seen = 0; fs_t = 0; fs_bad = 0; exp_line = 0;
        end
        if (a_clk != pat((fs_t / exp_n) % 8) || b_clk != a_clk) fs_bad++;
        if (blc || line_req || cr_pulse) fs_bad++;
        if (vd != (fs_t < LC)) vd_bad++;
        fs_t++;
      end else begin
        if (a_clk != 4'b1101 || b_clk != 4'b1101) hold_bad++;
        if (vd) vd_bad++;
      end
      if (hr_q && !high_req) begin
        chk(fs_t == SL * 8 * exp_n, "R4", "shift length", fs_t, SL * 8 * exp_n);
        chk(fs_bad == 0, "R5", "shift phase mismatches", fs_bad, 0);
        chk(vd_bad == 0, "R6", "frame pulse mismatches", vd_bad, 0);
        vd_bad = 0;
      end
      if (since_done >= 0) since_done++;
      if (dly > 0) begin
        dly--;
        if (dly == 0) begin
          chk(blc == isblk(exp_line - 1), "R8", "clamp at done", int'(blc), int'(isblk(exp_line - 1)));
          line_done = 1'b1; since_done = 0;
        end
      end
      if (line_req) begin
        chk(int'(line_num) == exp_line, "R7", "line index", int'(line_num), exp_line);
        chk(blc == isblk(exp_line), "R8", "clamp at request", int'(blc), int'(isblk(exp_line)));
        if (exp_line > 0) chk(since_done == 1, "R7", "request after done", since_done, 1);
        since_done = -1; exp_line++; lines_seen++; dly = 1 + int'($urandom % 3);
      end
      cr_q = cr_pulse; hr_q = high_req;
    end
  end

  task automatic do_trial(input int i, input int n, input int nfr, input bit mid);
    cfg_int = IW'(i); cfg_n = NW'(n);
    exp_int = i; exp_n = (n == 0) ? 1 : n;
    frames = 0;
    @(negedge clk); run = 1'b1;
    for (int f = 0; f < nfr; f++) begin
      do @(negedge clk); while (!high_req);
      if (f == nfr - 1) run = 1'b0;
      if (mid) begin cfg_int = IW'(9); cfg_n = NW'(7); end
      repeat (2) @(negedge clk);
    end
    do @(negedge clk); while (lines_seen != TL);
    repeat (6) @(negedge clk);
    hold_bad = 0;
    for (int c = 0; c < LC; c++) begin
      @(negedge clk);
      chk(!high_req && !cr_pulse && !line_req && !blc, "R9", "rest after readout",
          int'({high_req, cr_pulse, line_req, blc}), 0);
    end
    chk(hold_bad == 0, "R5", "hold pattern at rest", hold_bad, 0);
    chk(lines_seen == TL, "R7", "lines in last frame", lines_seen, TL);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!cr_pulse && !vd && !high_req && !blc && !line_req, "R1", "strobes after reset",
        int'({cr_pulse, vd, high_req, blc, line_req}), 0);
    chk(a_clk == 4'b1101 && b_clk == 4'b1101, "R1", "hold pattern after reset",
        int'({a_clk, b_clk}), 8'hDD);
    mon_on = 1;
    do_trial(2, 1, 1, 0);   // R2 shutter and integration
    do_trial(0, 2, 1, 0);   // R3 no shutter from rest
    do_trial(0, 1, 2, 0);   // R3 back-to-back frames
    do_trial(1, 0, 1, 0);   // R4 divider zero acts as one
    do_trial(3, 3, 1, 1);   // R9 config change after capture
    do_trial(1, 2, 2, 0);   // R2 shutter between continuous frames
    for (int t = 0; t < 6; t++)
      do_trial(int'($urandom % 4), 1 + int'($urandom % 3), 1 + int'($urandom % 2), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule